// File: doc/BRIEF.md
# Timer Interrupt Request Flag Register

This block holds the pending-request flags of four timer interrupt sources in one 8-bit register on a simple read/write bus. Each flag is set by a one-cycle event pulse from its timer, or by software writing a 1 to it. Software can also clear a flag by writing a 0. The flags are combined with an externally held enable vector and a master enable bit. From that combination the block forms an interrupt request line and a vector index for the CPU. When the CPU accepts a request, it returns an acknowledge with the same index, and the block clears that flag.

A request that becomes visible because software wrote the flag register, or wrote the companion enable register, is not shown at once. It stays hidden until the CPU reports one more completed instruction after the cycle of the write. Requests raised by timer events bypass this hold. Among several visible requests, the lowest flag number is reported first.

Top module: `tmr_req_flags`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req` is 0. A read at any address other than `FLAG_ADDR` returns 0x00.
- R2: Flag i sits at register bit `FLAG_LSB`+i. With the default parameters, bit 4 is timer E (source 0), bit 5 is timer F (source 1), bit 6 is timer A (source 2) and bit 7 is timer B (source 3).
- R3: A pulse on `hw_evt[i]` sets flag i on the next clock edge, whatever the values of `ena_bits` and `irq_mie`.
- R4: `irq_req` is 1 only while some flag i is 1, `ena_bits[i]` is 1 and `irq_mie` is 1.
- R5: A bus write to `FLAG_ADDR` loads every flag from its data bit: a 1 sets the flag and a 0 clears it.
- R6: `ack_vld` with index i clears flag i on the next clock edge.
- R7: A timer event on flag i wins over a same-cycle acknowledge of i, and over a same-cycle write of 0 to i. The flag ends up 1.
- R8: A request that becomes active through a flag write, or through an enable-register write (`ena_wr`), is hidden from `irq_req`. It stays hidden until `instr_done` is seen on a cycle after the write cycle. An `instr_done` in the same cycle as the write does not release it.
- R9: A request raised by a timer event while its enable and the master enable are already 1 appears on `irq_req` in the cycle after the event, with no `instr_done` needed.
- R10: `irq_idx` gives the lowest-numbered visible request (timer E, then F, then A, then B).
- R11: Writes to register bits 0 to 3 have no effect, and those bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data (combinational) |
| hw_evt | input | NUM_SRC | Timer event pulses, one per source |
| ena_bits | input | NUM_SRC | Current value of the companion enable register |
| ena_wr | input | 1 | Strobe: the enable register is being written this cycle |
| irq_mie | input | 1 | Master interrupt enable |
| ack_vld | input | 1 | CPU accepts a request |
| ack_idx | input | IDX_W | Index of the accepted request |
| instr_done | input | 1 | Strobe: one instruction completed |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | IDX_W | Index of the reported request |

## Verification
The bench builds the block with its default parameters: four sources placed at bits 4 to 7 of an 8-bit register, and lowest-index-first selection. These values put the unused low nibble, the full four-way priority chain and every acknowledge index within reach. The bench drives colliding set and clear events on the same flag. It places `instr_done` on the write cycle itself and on later cycles, so that the edges of the post-write hold can be seen at the ports.

// File: rtl/trf_pkg.sv
package trf_pkg;

   // per-source state of the post-write hold
   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_SHUT = 1'b1
   } gate_e;

   // index width that never collapses to zero
   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/trf_flag_bank.sv
module trf_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_evt,
   input  logic         sw_wr,
   input  logic [N-1:0] sw_val,
   input  logic [N-1:0] ack_oh,
   output logic [N-1:0] flag_q
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         // hardware set outranks software write, which outranks acknowledge
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q[i] <= 1'b0;
            else if (hw_evt[i])
               flag_q[i] <= 1'b1;
            else if (sw_wr)
               flag_q[i] <= sw_val[i];
            else if (ack_oh[i])
               flag_q[i] <= 1'b0;
         end

         // R3
         evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_evt[i] |=> flag_q[i]);

         // R6
         ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_oh[i] && !hw_evt[i] && !(sw_wr && sw_val[i])) |=> !flag_q[i]);

         // R5
         sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_wr && !hw_evt[i]) |=> (flag_q[i] == $past(sw_val[i])));
      end
   endgenerate

endmodule

// File: rtl/trf_post_write_gate.sv
module trf_post_write_gate
   import trf_pkg::*;
#(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         qual_wr,
   input  logic         instr_done,
   input  logic [N-1:0] hw_evt,
   input  logic [N-1:0] active,
   output logic [N-1:0] held
);

   gate_e st_q [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_gate
         gate_e st_d;

         always_comb begin
            st_d = st_q[i];
            if (hw_evt[i]) begin
               st_d = GATE_OPEN;
            end else if (qual_wr) begin
               // a source not active yet may become active through this write
               if (!active[i])
                  st_d = GATE_SHUT;
               else if (instr_done)
                  st_d = GATE_OPEN;
            end else if (instr_done) begin
               st_d = GATE_OPEN;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               st_q[i] <= GATE_OPEN;
            else
               st_q[i] <= st_d;
         end

         assign held[i] = (st_q[i] == GATE_SHUT);

         // R8
         arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (qual_wr && !active[i] && !hw_evt[i]) |=> held[i]);

         // R8
         hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (held[i] && !instr_done && !hw_evt[i]) |=> held[i]);

         // R9
         evt_unheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_evt[i] |=> !held[i]);
      end
   endgenerate

endmodule

// File: rtl/trf_pick.sv
module trf_pick #(
   parameter int N         = 4,
   parameter int IDX_W     = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign any = |req_vec;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int k = N - 1; k >= 0; k--)
               if (req_vec[k]) idx = IDX_W'(k);
         end

         // R10
         lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            any |-> ((req_vec & ((N'(1) << idx) - N'(1))) == '0));
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int k = 0; k < N; k++)
               if (req_vec[k]) idx = IDX_W'(k);
         end
      end
   endgenerate

   // R10
   idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req_vec[idx]);

endmodule

// File: rtl/tmr_req_flags.sv
module tmr_req_flags #(
   parameter int                NUM_SRC   = 4,
   parameter int                REG_W     = 8,
   parameter int                FLAG_LSB  = 4,
   parameter int                ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD,
   parameter bit                LOW_FIRST = 1'b1,
   localparam int               IDX_W     = trf_pkg::idx_w(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_SRC-1:0] hw_evt,
   input  logic [NUM_SRC-1:0] ena_bits,
   input  logic               ena_wr,
   input  logic               irq_mie,
   input  logic               ack_vld,
   input  logic [IDX_W-1:0]   ack_idx,
   input  logic               instr_done,
   output logic               irq_req,
   output logic [IDX_W-1:0]   irq_idx
);

   // elaboration checks on the parameter set
   generate
      if (NUM_SRC < 1) begin : g_bad_count
         $error("tmr_req_flags: NUM_SRC must be at least 1");
      end
      if (FLAG_LSB < 0 || FLAG_LSB + NUM_SRC > REG_W) begin : g_bad_map
         $error("tmr_req_flags: flag field does not fit in the register");
      end
      if (NUM_SRC > (1 << IDX_W)) begin : g_bad_idx
         $error("tmr_req_flags: index width too small");
      end
   endgenerate

   logic               addr_hit;
   logic               wr_hit;
   logic [NUM_SRC-1:0] sw_val;
   logic [NUM_SRC-1:0] ack_oh;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] active;
   logic [NUM_SRC-1:0] held;
   logic [NUM_SRC-1:0] visible;
   logic               qual_wr;
   logic               unused_wdata;

   assign addr_hit     = (bus_addr == FLAG_ADDR);
   assign wr_hit       = bus_wr && addr_hit;
   assign sw_val       = bus_wdata[FLAG_LSB +: NUM_SRC];
   assign unused_wdata = ^bus_wdata;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++)
         ack_oh[i] = ack_vld && (ack_idx == IDX_W'(i));
   end

   trf_flag_bank #(.N(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_evt (hw_evt),
      .sw_wr  (wr_hit),
      .sw_val (sw_val),
      .ack_oh (ack_oh),
      .flag_q (flag_q)
   );

   assign active  = flag_q & ena_bits & {NUM_SRC{irq_mie}};
   assign qual_wr = wr_hit || ena_wr;

   trf_post_write_gate #(.N(NUM_SRC)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_wr    (qual_wr),
      .instr_done (instr_done),
      .hw_evt     (hw_evt),
      .active     (active),
      .held       (held)
   );

   assign visible = active & ~held;

   trf_pick #(.N(NUM_SRC), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_vec (visible),
      .any     (irq_req),
      .idx     (irq_idx)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_hit)
         bus_rdata[FLAG_LSB +: NUM_SRC] = flag_q;
   end

   // R4
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_mie && ((flag_q & ena_bits) != '0)));

   // R6
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && !hw_evt[ack_idx] && !wr_hit) |=> !flag_q[$past(ack_idx)]);

endmodule

// File: tb/tb_tmr_req_flags.sv
`timescale 1ns/1ps
module tb_tmr_req_flags;

   localparam logic [3:0] FA = 4'hD;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] bus_addr;
   logic       bus_wr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic [3:0] hw_evt;
   logic [3:0] ena_bits;
   logic       ena_wr;
   logic       irq_mie;
   logic       ack_vld;
   logic [1:0] ack_idx;
   logic       instr_done;
   logic       irq_req;
   logic [1:0] irq_idx;

   int n_run  = 0;
   int n_fail = 0;
   bit done_all = 1'b0;

   always #10 clk = ~clk;

   tmr_req_flags dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
      .ena_bits(ena_bits), .ena_wr(ena_wr), .irq_mie(irq_mie),
      .ack_vld(ack_vld), .ack_idx(ack_idx), .instr_done(instr_done),
      .irq_req(irq_req), .irq_idx(irq_idx)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_reg(input logic [7:0] d);
      bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic pulse_evt(input logic [3:0] m);
      hw_evt = m;
      tick();
      hw_evt = '0;
   endtask

   task automatic do_ack(input logic [1:0] i);
      ack_vld = 1'b1; ack_idx = i;
      tick();
      ack_vld = 1'b0;
   endtask

   task automatic pulse_done();
      instr_done = 1'b1;
      tick();
      instr_done = 1'b0;
   endtask

   task automatic clean();
      ena_bits = '0; irq_mie = 1'b0;
      wr_reg(8'h00);
      pulse_done();
   endtask

   task automatic t_reset();
      chk("R1 reset read", bus_rdata, 8'h00);
      chk("R1 reset irq", irq_req, 1'b0);
      bus_addr = 4'h3; #1;
      chk("R1 other address", bus_rdata, 8'h00);
      bus_addr = FA; #1;
   endtask

   task automatic t_hw_set();
      clean();
      pulse_evt(4'b0010);
      chk("R3 set with enables off", bus_rdata, 8'h20);
      chk("R2 timer F at bit5", bus_rdata[5], 1'b1);
      chk("R4 no irq without enable", irq_req, 1'b0);
      ena_bits = 4'b0010; #1;
      chk("R4 no irq without master", irq_req, 1'b0);
      irq_mie = 1'b1; #1;
      chk("R4 irq when all set", irq_req, 1'b1);
      chk("R4 idx", irq_idx, 2'd1);
   endtask

   task automatic t_hw_nodelay();
      clean();
      ena_bits = 4'hF; irq_mie = 1'b1;
      pulse_evt(4'b0100);
      chk("R9 event not delayed", irq_req, 1'b1);
      chk("R9 idx timer A", irq_idx, 2'd2);
   endtask

   task automatic t_sw_delay();
      clean();
      ena_bits = 4'hF; irq_mie = 1'b1;
      wr_reg(8'h80);
      chk("R5 write sets", bus_rdata, 8'h80);
      chk("R8 held after write", irq_req, 1'b0);
      tick(); tick(); tick();
      chk("R8 still held", irq_req, 1'b0);
      pulse_done();
      chk("R8 released", irq_req, 1'b1);
      chk("R8 idx timer B", irq_idx, 2'd3);
      // done in the write cycle itself does not count
      clean();
      ena_bits = 4'hF; irq_mie = 1'b1;
      instr_done = 1'b1;
      wr_reg(8'h40);
      instr_done = 1'b0;
      chk("R8 same-cycle done ignored", irq_req, 1'b0);
      pulse_done();
      chk("R8 release after later done", irq_req, 1'b1);
   endtask

   task automatic t_ena_delay();
      clean();
      irq_mie = 1'b1;
      wr_reg(8'h10);
      pulse_done();
      ena_wr = 1'b1;
      tick();
      ena_wr = 1'b0; ena_bits = 4'b0001; #1;
      chk("R8 held after enable write", irq_req, 1'b0);
      tick();
      chk("R8 still held enable", irq_req, 1'b0);
      pulse_done();
      chk("R8 enable released", irq_req, 1'b1);
      chk("R8 idx timer E", irq_idx, 2'd0);
      do_ack(2'd0);
      chk("R6 ack clears", bus_rdata, 8'h00);
      chk("R6 irq drops", irq_req, 1'b0);
   endtask

   task automatic t_prio();
      clean();
      ena_bits = 4'hF; irq_mie = 1'b1;
      pulse_evt(4'b1101);
      chk("R10 lowest first", irq_idx, 2'd0);
      do_ack(2'd0);
      chk("R10 next", irq_idx, 2'd2);
      chk("R6 flags after ack", bus_rdata, 8'hC0);
      do_ack(2'd2);
      chk("R10 last", irq_idx, 2'd3);
      do_ack(2'd3);
      chk("R6 all served", irq_req, 1'b0);
   endtask

   task automatic t_collide();
      clean();
      pulse_evt(4'b0001);
      hw_evt = 4'b0001; ack_vld = 1'b1; ack_idx = 2'd0;
      tick();
      hw_evt = '0; ack_vld = 1'b0;
      chk("R7 event beats ack", bus_rdata, 8'h10);
      hw_evt = 4'b0001;
      wr_reg(8'h00);
      hw_evt = '0;
      chk("R7 event beats write 0", bus_rdata, 8'h10);
      wr_reg(8'h00);
      chk("R5 write 0 clears", bus_rdata, 8'h00);
   endtask

   task automatic t_unused();
      clean();
      wr_reg(8'hFF);
      chk("R11 low bits ignored", bus_rdata, 8'hF0);
      wr_reg(8'h0F);
      chk("R11 low bits read 0", bus_rdata, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; bus_addr = FA; bus_wr = 1'b0; bus_wdata = '0;
      hw_evt = '0; ena_bits = '0; ena_wr = 1'b0; irq_mie = 1'b0;
      ack_vld = 1'b0; ack_idx = '0; instr_done = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1; #1;
      t_reset();
      t_hw_set();
      t_hw_nodelay();
      t_sw_delay();
      t_ena_delay();
      t_prio();
      t_collide();
      t_unused();
      done_all = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_all) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule